// File: doc/BRIEF.md
# System Management Interrupt Controller

This block decides when a simple sequential processor core leaves normal execution for a system management handler, and when it comes back. An asynchronous, active-low request pin is synchronised. A high-to-low transition on it is latched as a single pending request. The block then weighs that request against the core's other interrupt sources and against any locked bus sequence in progress. When the request wins, the block pulses an enter strobe to the core for one cycle and pulls an active-low mode flag low. The flag stays low until the core reports that it has executed the resume instruction.

The core supplies two boundary strobes. One marks the end of a whole instruction. The other marks the end of each pass of a repeated string instruction. Either strobe is a legal point to take an interrupt. At such a point the block also grants the non-maskable and maskable interrupt requests, in that priority order, when no management request claims it. A request edge that arrives while the mode is already running cannot re-enter the handler. It is held and serviced at the first boundary after the resume.

Top module: `smm_irq_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `mgmt_active_n` is 1, `enter_pulse`, `nmi_take` and `intr_take` are 0, and no request is pending.
- R2: A request is recorded only on a 1-to-0 transition of `smi_req_n`, seen after SYNC_STAGES synchroniser flops and one edge-detect flop. Holding the pin low records nothing further.
- R3: A pending request is accepted only in a cycle where `instr_bnd` or `str_iter` is 1 (the string-iteration strobe counts when STR_ITER_EN is 1). `enter_pulse` is 1 in the cycle after acceptance.
- R4: No request, NMI or INTR is accepted in a cycle with `bus_locked` at 1. A pending request waits until a boundary with the lock released.
- R5: At an open boundary, priority is management request, then `nmi_req`, then `intr_req`. At most one of `enter_pulse`, `nmi_take`, `intr_take` is 1 in any cycle.
- R6: While the mode is active, no further entry occurs. A falling edge seen during the mode stays pending and is accepted at the first open boundary after the resume.
- R7: `mgmt_active_n` goes to 0 together with `enter_pulse`. It stays 0 until the cycle after `resume` is sampled at 1, and then returns to 1.
- R8: `enter_pulse` lasts exactly one cycle per accepted request, even if a boundary strobe is held high.
- R9: The pending flag is one bit. Several falling edges before acceptance yield exactly one entry.
- R10: While the mode is active, `nmi_req` and `intr_req` are not granted.
- R11: `resume` has no effect while the mode is not active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smi_req_n | input | 1 | Asynchronous active-low management request pin |
| instr_bnd | input | 1 | Whole-instruction boundary strobe |
| str_iter | input | 1 | Repeated-string iteration boundary strobe |
| bus_locked | input | 1 | A locked bus sequence is in progress |
| nmi_req | input | 1 | Non-maskable interrupt request |
| intr_req | input | 1 | Maskable interrupt request |
| resume | input | 1 | Core executed the resume instruction |
| enter_pulse | output | 1 | One-cycle strobe: enter the management handler |
| mgmt_active_n | output | 1 | Active-low: management mode in progress |
| nmi_take | output | 1 | One-cycle grant of the non-maskable interrupt |
| intr_take | output | 1 | One-cycle grant of the maskable interrupt |

## Verification
The hardest case to reach from the ports is a request edge that lands while the handler is already running. It must survive boundary strobes that would otherwise accept it, and then fire exactly once after the resume. The stimulus enters the mode, drops the pin again, waits out the synchroniser latency and strobes boundaries during the mode. It then resumes and shows the deferred entry. A similar sequence sends several edges before acceptance, to show that they merge. The bench's behavioural model tracks the pin history as a queue, so every cycle of these sequences is compared, not only the end points.

// File: rtl/smm_pkg.sv
package smm_pkg;
   localparam int DEF_SYNC_STAGES = 2;

   // one decision per cycle from the arbiter
   typedef struct packed {
      logic smi;
      logic nmi;
      logic intr;
   } grant_t;
endpackage

// File: rtl/smm_sync.sv
module smm_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_depth
      $error("smm_sync: STAGES must be at least 2");
   end

   logic [LAST:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[LAST-1:0], d};
   end

   assign q = chain[LAST];
endmodule

// File: rtl/smm_edge_latch.sv
module smm_edge_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_n,    // synchronised active-low request
   input  logic taken,    // arbiter accepted the pending request
   output logic pending
);
   logic lvl_d;
   logic fell;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= 1'b1;
      else        lvl_d <= lvl_n;
   end

   assign fell = lvl_d & ~lvl_n;

   // single-bit store: further edges merge into one request
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pending <= 1'b0;
      else        pending <= fell | (pending & ~taken);
   end
endmodule

// File: rtl/smm_arbiter.sv
module smm_arbiter
   import smm_pkg::*;
#(
   parameter bit STR_ITER_EN = 1'b1
) (
   input  logic   instr_bnd,
   input  logic   str_iter,
   input  logic   bus_locked,
   input  logic   active,
   input  logic   pending,
   input  logic   nmi_req,
   input  logic   intr_req,
   output grant_t grant
);
   logic bnd;
   logic open_slot;

   if (STR_ITER_EN) begin : g_iter_bnd
      assign bnd = instr_bnd | str_iter;
   end else begin : g_instr_only
      assign bnd = instr_bnd;
   end

   assign open_slot = bnd & ~bus_locked & ~active;

   always_comb begin
      grant = '0;
      if (open_slot) begin
         if (pending)      grant.smi  = 1'b1;
         else if (nmi_req) grant.nmi  = 1'b1;
         else if (intr_req) grant.intr = 1'b1;
      end
   end
endmodule

// File: rtl/smm_mode.sv
module smm_mode
   import smm_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  grant_t grant,
   input  logic   resume,
   output logic   active,
   output logic   enter_q,
   output logic   nmi_q,
   output logic   intr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         enter_q <= 1'b0;
         nmi_q   <= 1'b0;
         intr_q  <= 1'b0;
      end else begin
         enter_q <= grant.smi;
         nmi_q   <= grant.nmi;
         intr_q  <= grant.intr;
         if (grant.smi)   active <= 1'b1;
         else if (resume) active <= 1'b0;
      end
   end
endmodule

// File: rtl/smm_irq_ctrl.sv
module smm_irq_ctrl
   import smm_pkg::*;
#(
   parameter int SYNC_STAGES = DEF_SYNC_STAGES,
   parameter bit STR_ITER_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smi_req_n,
   input  logic instr_bnd,
   input  logic str_iter,
   input  logic bus_locked,
   input  logic nmi_req,
   input  logic intr_req,
   input  logic resume,
   output logic enter_pulse,
   output logic mgmt_active_n,
   output logic nmi_take,
   output logic intr_take
);
   logic   smi_s_n;
   logic   pending;
   logic   active;
   grant_t grant;

   smm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (smi_req_n),
      .q     (smi_s_n)
   );

   smm_edge_latch u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_n   (smi_s_n),
      .taken   (grant.smi),
      .pending (pending)
   );

   smm_arbiter #(.STR_ITER_EN(STR_ITER_EN)) u_arb (
      .instr_bnd  (instr_bnd),
      .str_iter   (str_iter),
      .bus_locked (bus_locked),
      .active     (active),
      .pending    (pending),
      .nmi_req    (nmi_req),
      .intr_req   (intr_req),
      .grant      (grant)
   );

   smm_mode u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .grant   (grant),
      .resume  (resume),
      .active  (active),
      .enter_q (enter_pulse),
      .nmi_q   (nmi_take),
      .intr_q  (intr_take)
   );

   assign mgmt_active_n = ~active;
endmodule

// File: rtl/smm_irq_ctrl_chk.sv
module smm_irq_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic instr_bnd,
   input logic str_iter,
   input logic bus_locked,
   input logic resume,
   input logic enter_pulse,
   input logic mgmt_active_n,
   input logic nmi_take,
   input logic intr_take
);
   logic seen_edge;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_edge <= 1'b0;
      else        seen_edge <= 1'b1;
   end

   a_r3_enter_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_edge && enter_pulse) |-> $past(instr_bnd || str_iter));

   a_r4_no_entry_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_edge && (enter_pulse || nmi_take || intr_take)) |-> !$past(bus_locked));

   a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({enter_pulse, nmi_take, intr_take}));

   a_r6_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_edge && enter_pulse) |-> $past(mgmt_active_n));

   a_r7_flag_with_enter: assert property (@(posedge clk) disable iff (!rst_n)
      enter_pulse |-> !mgmt_active_n);

   a_r7_hold_until_resume: assert property (@(posedge clk) disable iff (!rst_n)
      (!mgmt_active_n && !resume) |=> !mgmt_active_n);

   a_r8_one_cycle_enter: assert property (@(posedge clk) disable iff (!rst_n)
      enter_pulse |=> !enter_pulse);

   a_r10_no_grant_in_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_edge && (nmi_take || intr_take)) |-> $past(mgmt_active_n));
endmodule

bind smm_irq_ctrl smm_irq_ctrl_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .instr_bnd     (instr_bnd),
   .str_iter      (str_iter),
   .bus_locked    (bus_locked),
   .resume        (resume),
   .enter_pulse   (enter_pulse),
   .mgmt_active_n (mgmt_active_n),
   .nmi_take      (nmi_take),
   .intr_take     (intr_take)
);

// File: tb/sim_smm_irq_ctrl.sv
module sim_smm_irq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int SYNC       = 2;

   logic clk = 0, rst_n = 0, smi_n = 1, ibnd = 0, sbnd = 0, lk = 0;
   logic nmi = 0, intr = 0, rsm = 0;
   logic enter, act_n, nmi_t, intr_t;

   int    checks = 0, fails = 0, enters = 0;
   string tag = "R1";
   bit    done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   smm_irq_ctrl #(.SYNC_STAGES(SYNC), .STR_ITER_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .smi_req_n(smi_n), .instr_bnd(ibnd),
      .str_iter(sbnd), .bus_locked(lk), .nmi_req(nmi), .intr_req(intr),
      .resume(rsm), .enter_pulse(enter), .mgmt_active_n(act_n),
      .nmi_take(nmi_t), .intr_take(intr_t)
   );

   // behavioural reference: pin history queue plus a few flags
   bit m_hist[$];
   bit m_prev = 1, m_pend = 0, m_act = 0, m_ent = 0, m_nt = 0, m_it = 0;
   bit s_now, fell, open_b, acc;

   initial for (int i = 0; i < SYNC; i++) m_hist.push_back(1'b1);

   always @(posedge clk) begin
      if (!rst_n) begin
         m_prev = 1; m_pend = 0; m_act = 0; m_ent = 0; m_nt = 0; m_it = 0;
         for (int i = 0; i < SYNC; i++) m_hist[i] = 1'b1;
      end else begin
         s_now  = m_hist[SYNC-1];
         fell   = m_prev && !s_now;
         open_b = (ibnd || sbnd) && !lk && !m_act;
         acc    = open_b && m_pend;
         m_nt   = open_b && !m_pend && nmi;
         m_it   = open_b && !m_pend && !nmi && intr;
         m_ent  = acc;
         if (acc) m_act = 1; else if (rsm) m_act = 0;
         m_pend = fell || (m_pend && !acc);
         m_prev = s_now;
         m_hist.push_front(smi_n);
         void'(m_hist.pop_back());
      end
   end

   always @(negedge clk) if (!done) begin
      checks++;
      if (enter !== m_ent || act_n !== !m_act || nmi_t !== m_nt || intr_t !== m_it) begin
         fails++;
         $display("FAIL %s: act enter=%b act_n=%b nmi=%b intr=%b exp enter=%b act_n=%b nmi=%b intr=%b",
                  tag, enter, act_n, nmi_t, intr_t, m_ent, !m_act, m_nt, m_it);
      end
      if (enter === 1'b1) enters++;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bnd_pulse();
      ibnd = 1; tick(1); ibnd = 0; tick(1);
   endtask

   task automatic smi_edge();
      smi_n = 0; tick(2); smi_n = 1; tick(SYNC + 3);
   endtask

   task automatic do_resume();
      rsm = 1; tick(1); rsm = 0; tick(1);
   endtask

   task automatic check_eq(input string t, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", t, act, exp);
      end
   endtask

   task automatic summary();
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
   end

   initial begin
      tag = "R1 reset";
      tick(3); rst_n = 1; tick(2);
      bnd_pulse(); tick(2);
      check_eq("R1 no entry without request", enters, 0);

      tag = "R2 edge capture"; smi_edge();
      tag = "R3 boundary needed"; tick(3);
      check_eq("R3 no entry before boundary", enters, 0);
      bnd_pulse(); tick(2);
      check_eq("R3 entry at boundary", enters, 1);
      tag = "R7 held until resume"; tick(4); do_resume(); tick(2);

      tag = "R11 resume idle"; do_resume(); tick(2);

      tag = "R4 R8 lock"; smi_edge();
      lk = 1; ibnd = 1; tick(4);
      check_eq("R4 blocked by lock", enters, 1);
      lk = 0; tick(3); ibnd = 0; tick(2);
      check_eq("R8 single pulse", enters, 2);
      do_resume();

      tag = "R5 priority"; smi_edge();
      nmi = 1; intr = 1; bnd_pulse(); tick(1);
      check_eq("R5 management wins", enters, 3);
      tag = "R10 masked in mode"; bnd_pulse(); bnd_pulse();
      do_resume();
      tag = "R5 nmi over intr"; bnd_pulse(); nmi = 0;
      tag = "R5 intr last"; bnd_pulse(); intr = 0; tick(2);

      tag = "R6 deferred"; smi_edge(); bnd_pulse();
      smi_edge(); bnd_pulse(); bnd_pulse();
      check_eq("R6 no reentry", enters, 4);
      do_resume(); bnd_pulse(); tick(1);
      check_eq("R6 serviced after resume", enters, 5);
      do_resume();

      tag = "R9 merge";
      smi_n = 0; tick(2); smi_n = 1; tick(2); smi_n = 0; tick(2); smi_n = 1; tick(2);
      smi_n = 0; tick(2); smi_n = 1; tick(SYNC + 3);
      bnd_pulse(); do_resume(); bnd_pulse(); bnd_pulse();
      check_eq("R9 one entry", enters, 6);

      tag = "R3 string iteration"; smi_edge();
      sbnd = 1; tick(1); sbnd = 0; tick(2);
      check_eq("R3 iteration boundary", enters, 7);
      do_resume();

      tag = "R2 level hold"; smi_n = 0; tick(SYNC + 3);
      bnd_pulse(); do_resume(); bnd_pulse(); bnd_pulse();
      check_eq("R2 level does not retrigger", enters, 8);
      smi_n = 1; tick(4);

      summary();
   end
endmodule